// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four level-sensitive PCI interrupt lines onto a sixteen-line input bus of a legacy interrupt controller. Every PCI line has its own byte-wide route register. The register either names one legacy IRQ number or leaves the line unconnected.

Several PCI lines may target the same legacy IRQ. That IRQ then carries the wired-OR of every line steered to it. It stays high until all of those lines have gone low. The route registers sit at four consecutive byte offsets, starting at 0x60, of a configuration space. A simple byte write/read port gives access to them.

All sixteen outputs come from one register. Each output is recomputed on every clock from the live line levels and the current routes. A reroute therefore releases an IRQ on the next edge if nothing else still holds it.

Top module: `pci_irq_router`

## Requirements
- R1: After reset every route register reads 0x80, which means disabled. All sixteen legacy IRQ outputs are low, whatever the PCI line levels are.
- R2: A write with the address equal to 0x60 + n (n = 0..3) stores the byte in the route register of PCI line n. A read at that address returns the last byte written.
- R3: A route value from 0 to 15 steers the line onto the legacy IRQ with that number, output bit index = value. A value from 16 to 255 steers the line nowhere, so it drives no output.
- R4: Each legacy IRQ output is the logical OR of the levels of all PCI lines whose route register holds that IRQ number.
- R5: Outputs are levels, not pulses. A shared legacy IRQ goes low only when every PCI line steered to it is low.
- R6: A route register write recomputes all sixteen outputs. The IRQ that the line previously targeted drops if no other high line still targets it.
- R7: The outputs are registered. A change of a line level seen at a clock edge, or a route written at a clock edge, appears on the outputs at the following clock edge and not earlier.
- R8: A write to any address outside 0x60 to 0x63 changes no route register and no output. A read of such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pci_int_level | input | 4 | Current level of each PCI interrupt line, bit n is line n |
| cfg_wr_en | input | 1 | Write strobe for the route register port |
| cfg_addr | input | 8 | Byte address for both the write and the read |
| cfg_wr_data | input | 8 | Byte to write |
| cfg_rd_data | output | 8 | Byte read at cfg_addr (combinational) |
| legacy_irq | output | 16 | Level of each legacy IRQ, bit k is IRQ k |

## Verification
The bench goes after the decode boundary first. It walks every one of the 256 route values on each line while the other lines are parked. A design that compares against the wrong bound, or looks only at the low nibble, lights an IRQ for values such as 16, 0x80 or 0xFF.

It then sweeps all sixteen level combinations over route sets that share IRQs. Shared targets are where a design that lets the last matching line win, instead of OR-ing, drops an IRQ while another line still holds it.

Finally it moves lines away from a shared IRQ one by one and writes to neighbouring addresses. These catch a stale output that is never released, and a decoder that aliases 0x64 or 0x5F onto a route register. A direct latency probe catches an output that is combinational or that lags by two edges.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;
    localparam int unsigned ROUTE_W = 8;
    typedef logic [ROUTE_W-1:0] route_t;
    // bit 7 set: line steered nowhere
    localparam route_t ROUTE_RESET = 8'h80;
endpackage

// File: rtl/pci_irq_route_regs.sv
module pci_irq_route_regs
    import pci_irq_router_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h60
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  route_t                      wr_data,
    output route_t                      rd_data,
    output route_t [NUM_LINES-1:0]      routes
);
    logic [NUM_LINES-1:0] sel;
    route_t [NUM_LINES-1:0] routes_q;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign sel[i] = (addr == ADDR_W'(BASE_ADDR + i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                routes_q[i] <= ROUTE_RESET;
            end else if (wr_en && sel[i]) begin
                routes_q[i] <= wr_data;
            end
        end

        AST_ROUTE_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(BASE_ADDR + i)) |=> routes_q[i] == $past(wr_data)); // R2
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (sel[i]) rd_data = routes_q[i];
        end
    end

    assign routes = routes_q;

    AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == '0) |=> $stable(routes_q)); // R8
endmodule

// File: rtl/pci_irq_route_decode.sv
module pci_irq_route_decode
    import pci_irq_router_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int NUM_IRQS  = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  route_t [NUM_LINES-1:0]                routes,
    output logic   [NUM_LINES-1:0][NUM_IRQS-1:0]  hit
);
    localparam int IDX_W = (NUM_IRQS > 1) ? $clog2(NUM_IRQS) : 1;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_dec
        logic in_range;
        assign in_range = (routes[i] < ROUTE_W'(NUM_IRQS));
        assign hit[i]   = in_range ? (NUM_IRQS'(1) << routes[i][IDX_W-1:0]) : '0;

        AST_ONE_TARGET_AT_MOST: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hit[i])); // R3
        AST_HIGH_ROUTE_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
            (routes[i] >= ROUTE_W'(NUM_IRQS)) |-> hit[i] == '0); // R3
    end
endmodule

// File: rtl/pci_irq_merge.sv
module pci_irq_merge #(
    parameter int NUM_LINES = 4,
    parameter int NUM_IRQS  = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_LINES-1:0]                 level,
    input  logic [NUM_LINES-1:0][NUM_IRQS-1:0]   hit,
    output logic [NUM_IRQS-1:0]                  irq_q
);
    logic [NUM_IRQS-1:0] irq_d;

    always_comb begin
        irq_d = '0;
        for (int j = 0; j < NUM_IRQS; j++) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                irq_d[j] = irq_d[j] | (level[i] & hit[i][j]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    AST_QUIET_WHEN_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |=> irq_q == '0); // R5
    AST_NO_MORE_IRQS_THAN_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (level != '0) |=> $countones(irq_q) <= $countones($past(level))); // R4
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import pci_irq_router_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int NUM_IRQS  = 16,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h60
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  pci_int_level,
    input  logic                  cfg_wr_en,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [ROUTE_W-1:0]    cfg_wr_data,
    output logic [ROUTE_W-1:0]    cfg_rd_data,
    output logic [NUM_IRQS-1:0]   legacy_irq
);
    route_t [NUM_LINES-1:0]               routes;
    logic   [NUM_LINES-1:0][NUM_IRQS-1:0] hit;

    pci_irq_route_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .addr    (cfg_addr),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .routes  (routes)
    );

    pci_irq_route_decode #(
        .NUM_LINES (NUM_LINES),
        .NUM_IRQS  (NUM_IRQS)
    ) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .routes (routes),
        .hit    (hit)
    );

    pci_irq_merge #(
        .NUM_LINES (NUM_LINES),
        .NUM_IRQS  (NUM_IRQS)
    ) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (pci_int_level),
        .hit   (hit),
        .irq_q (legacy_irq)
    );

    AST_RESET_OUTPUTS_LOW: assert property (@(posedge clk)
        !rst_n |=> legacy_irq == '0); // R1
endmodule

// File: tb/pci_irq_router_tb.sv
module pci_irq_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pci_int_level = '0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic [7:0]  cfg_rd_data;
    logic [15:0] legacy_irq;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] exp_route [4];

    always #4 clk = ~clk;

    pci_irq_router u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pci_int_level (pci_int_level),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_addr      (cfg_addr),
        .cfg_wr_data   (cfg_wr_data),
        .cfg_rd_data   (cfg_rd_data),
        .legacy_irq    (legacy_irq)
    );

    function automatic logic [15:0] model(input logic [3:0] lv);
        logic [15:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) begin
            if (lv[i] && exp_route[i] < 8'd16) r[exp_route[i][3:0]] = 1'b1;
        end
        return r;
    endfunction

    task automatic chk16(input logic [15:0] got, input logic [15:0] exp, input string tag);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s legacy_irq got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk8(input logic [7:0] got, input logic [7:0] exp, input string tag);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s rd_data got %h expected %h", tag, got, exp);
        end
    endtask

    // called at a negedge; leaves at a negedge with the route in place
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (a >= 8'h60 && a <= 8'h63) exp_route[a - 8'h60] = d;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        cfg_addr = a;
        #1;
        chk8(cfg_rd_data, exp, tag);
    endtask

    // change levels at a negedge, sample after the next rising edge
    task automatic lv_check(input logic [3:0] lv, input string tag);
        pci_int_level = lv;
        @(negedge clk);
        chk16(legacy_irq, model(lv), tag);
    endtask

    initial begin
        #1200000;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) exp_route[i] = 8'h80;
        pci_int_level = 4'hF;
        repeat (3) @(negedge clk);
        chk16(legacy_irq, 16'h0, "R1 during reset");
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) rd(8'h60 + 8'(i), 8'h80, "R1 reset route");
        @(negedge clk);
        chk16(legacy_irq, 16'h0, "R1 disabled routes, all lines high");

        // every route value on every line, other lines parked at 0x80
        for (int ln = 0; ln < 4; ln++) begin
            for (int v = 0; v < 256; v++) begin
                wr(8'h60 + 8'(ln), 8'(v));
                rd(8'h60 + 8'(ln), 8'(v), "R2 readback");
                @(negedge clk);
                chk16(legacy_irq, (v < 16) ? (16'h1 << v) : 16'h0, "R3 route sweep");
            end
            wr(8'h60 + 8'(ln), 8'h80);
        end

        // shared targets, all level combinations
        for (int p = 0; p < 5; p++) begin
            logic [7:0] set [4];
            case (p)
                0: set = '{8'd3, 8'd3, 8'd3, 8'd3};
                1: set = '{8'd0, 8'd1, 8'd2, 8'd3};
                2: set = '{8'd5, 8'd5, 8'd9, 8'h10};
                3: set = '{8'd15, 8'd0, 8'd15, 8'hFF};
                default: set = '{8'd7, 8'd7, 8'd12, 8'd12};
            endcase
            for (int i = 0; i < 4; i++) wr(8'h60 + 8'(i), set[i]);
            for (int lv = 0; lv < 16; lv++) lv_check(4'(lv), "R4 shared OR sweep");
            // drop lines one at a time from all high: R5
            lv_check(4'hF, "R5 all high");
            lv_check(4'hE, "R5 line0 low");
            lv_check(4'hC, "R5 lines0-1 low");
            lv_check(4'h8, "R5 only line3");
            lv_check(4'h0, "R5 all low");
        end

        // reroute release
        wr(8'h60, 8'd4); wr(8'h61, 8'd4); wr(8'h62, 8'h80); wr(8'h63, 8'h80);
        lv_check(4'b0011, "R6 both on irq4");
        chk16(legacy_irq, 16'h0010, "R6 irq4 held");
        wr(8'h60, 8'd6);
        @(negedge clk);
        chk16(legacy_irq, 16'h0050, "R6 line0 moved, irq4 still held by line1");
        wr(8'h61, 8'd6);
        @(negedge clk);
        chk16(legacy_irq, 16'h0040, "R6 irq4 released");
        wr(8'h60, 8'h90);
        @(negedge clk);
        chk16(legacy_irq, 16'h0040, "R6 irq6 kept by line1");

        // latency: one edge, not zero, not two
        wr(8'h60, 8'd2); wr(8'h61, 8'h80);
        lv_check(4'b0000, "R7 baseline");
        pci_int_level = 4'b0001;
        #1;
        chk16(legacy_irq, 16'h0000, "R7 no combinational path");
        @(posedge clk); #1;
        chk16(legacy_irq, 16'h0004, "R7 after one edge");
        cfg_wr_en = 1'b1; cfg_addr = 8'h60; cfg_wr_data = 8'd9;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
        exp_route[0] = 8'd9;
        chk16(legacy_irq, 16'h0004, "R7 route written, output not yet moved");
        @(posedge clk); #1;
        chk16(legacy_irq, 16'h0200, "R7 route visible one edge later");
        @(negedge clk);

        // stray addresses
        pci_int_level = 4'hF;
        wr(8'h61, 8'd1); wr(8'h62, 8'd11); wr(8'h63, 8'h80);
        @(negedge clk);
        chk16(legacy_irq, model(4'hF), "R8 baseline");
        wr(8'h64, 8'd0); wr(8'h5F, 8'd0); wr(8'h00, 8'd0); wr(8'hFF, 8'd0); wr(8'hE0, 8'd0);
        @(negedge clk);
        chk16(legacy_irq, 16'h0A02 | 16'h0000, "R8 outputs unchanged");
        rd(8'h60, 8'd9, "R8 route0 intact");
        rd(8'h61, 8'd1, "R8 route1 intact");
        rd(8'h62, 8'd11, "R8 route2 intact");
        rd(8'h63, 8'h80, "R8 route3 intact");
        rd(8'h64, 8'h00, "R8 read outside");
        rd(8'h5F, 8'h00, "R8 read below");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule